// File: doc/BRIEF.md
# Framed Serial Transmitter with Address/Data Marking

This block turns one parallel character at a time into an asynchronous serial frame on a single line that rests high. A character enters through a valid/ready handshake. The framing fields are captured at the moment the character is accepted. Those fields give the number of data bits, what goes into the optional check slot after the data, and the value of a one-bit selector. The bit rate comes from a one-cycle baud tick supplied from outside, and every bit on the line lasts exactly from one tick to the next.

The check slot after the data bits can be used in four ways. It can carry a computed parity, even or odd. It can carry the selector bit as a constant. It can be left out. In multidrop use it carries an address/data marker, so a receiver on a shared line can tell station addresses apart from payload. In both the forced and multidrop ways, the selector bit itself is what goes out in the slot.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset, `txd` is high and `in_ready` is high.
- R2: `len_code` selects the number of data bits: 00 = 5, 01 = 6, 10 = 7, 11 = 8. Data bits go out least significant first, and data bits above the selected length are never sent.
- R3: With `par_mode` = 00, the slot after the data carries parity over the sent data bits. `par_sel` = 0 makes the count of ones in data plus slot even, and `par_sel` = 1 makes it odd.
- R4: With `par_mode` = 01, the slot after the data carries the value of `par_sel`.
- R5: With `par_mode` = 10, there is no slot, and the stop bit follows the last data bit directly.
- R6: With `par_mode` = 11 (multidrop), the slot carries the address/data marker `par_sel`: 1 = address, 0 = data.
- R7: A frame is one low start bit, the data bits, the slot if present, and one high stop bit. `txd` changes only on the clock edge that samples `tick` high, and it stays high while no frame is in progress.
- R8: `in_ready` falls on the edge that accepts a character (`in_valid` and `in_ready` both high). It rises again on the tick that ends the stop bit, and `txd` is high at that point.
- R9: The character and all framing fields are captured at acceptance. Changing `in_data`, `len_code`, `par_mode` or `par_sel` during a frame has no effect on that frame.
- R10: After acceptance, `txd` stays high until the next tick. That tick begins the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | One-cycle baud pulse; each bit lasts one tick interval |
| in_data | input | DATA_W (8) | Character to send |
| in_valid | input | 1 | Character is offered |
| in_ready | output | 1 | Transmitter can accept a character |
| len_code | input | LEN_CODE_W (2) | Data length code |
| par_mode | input | 2 | Slot use: 00 parity, 01 forced, 10 none, 11 multidrop |
| par_sel | input | 1 | Odd parity select, or forced slot value / address marker |
| txd | output | 1 | Serial line, idles high |

## Verification
The bench builds the block with its default parameters: an 8-bit maximum character and a 2-bit length code. That covers all four lengths from 5 to 8 bits and frames of 7 to 11 bit times. Random characters, in all four slot modes and both selector values, are sent with random gaps between ticks. The bench overwrites the inputs right after each acceptance, so any framing that is not held through the whole frame shows up in the captured frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Use of the slot that follows the data bits
  typedef enum logic [1:0] {
    PM_PARITY = 2'b00,
    PM_FORCE  = 2'b01,
    PM_NONE   = 2'b10,
    PM_MULTI  = 2'b11
  } par_mode_e;

  // Sequencer states
  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_WAIT = 2'b01,
    SQ_SEND = 2'b10
  } seq_state_e;

endpackage

// File: rtl/tx_parity_gen.sv
module tx_parity_gen #(
  parameter int DATA_W     = 8,
  parameter int LEN_CODE_W = 2,
  localparam int MIN_LEN   = DATA_W - (1 << LEN_CODE_W) + 1,
  localparam int NUM_W     = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0]     data,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  odd_sel,
  output logic [NUM_W-1:0]      num_data,
  output logic                  par_bit
);

  logic [DATA_W-1:0] masked;

  assign num_data = NUM_W'(MIN_LEN) + NUM_W'(len_code);

  // Bits below the minimum length are always sent; the rest depend on the code
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < MIN_LEN) begin : g_fixed
      assign masked[i] = data[i];
    end else begin : g_var
      assign masked[i] = data[i] & (NUM_W'(i) < num_data);
    end
  end

  assign par_bit = (^masked) ^ odd_sel;

endmodule

// File: rtl/tx_char_format.sv
module tx_char_format
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LEN_CODE_W = 2,
  localparam int FRAME_W   = DATA_W + 3,
  localparam int CNT_W     = $clog2(FRAME_W + 1),
  localparam int NUM_W     = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0]     data,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic [1:0]            par_mode,
  input  logic                  par_sel,
  output logic [FRAME_W-1:0]    frame,
  output logic [CNT_W-1:0]      nbits
);

  logic [NUM_W-1:0] num_data;
  logic             par_bit;
  logic             has_slot;
  logic             slot_bit;
  par_mode_e        mode;

  tx_parity_gen #(
    .DATA_W     (DATA_W),
    .LEN_CODE_W (LEN_CODE_W)
  ) u_par (
    .data     (data),
    .len_code (len_code),
    .odd_sel  (par_sel),
    .num_data (num_data),
    .par_bit  (par_bit)
  );

  assign mode = par_mode_e'(par_mode);

  always_comb begin
    has_slot = 1'b1;
    slot_bit = 1'b1;
    unique case (mode)
      PM_PARITY: slot_bit = par_bit;
      PM_FORCE:  slot_bit = par_sel;
      PM_MULTI:  slot_bit = par_sel;
      PM_NONE:   has_slot = 1'b0;
      default:   has_slot = 1'b0;
    endcase
  end

  // Bit 0 goes out first: start, data LSB first, optional slot, stop (ones fill)
  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (NUM_W'(i) < num_data) frame[1 + i] = data[i];
    end
    if (has_slot) frame[1 + int'(num_data)] = slot_bit;
  end

  assign nbits = CNT_W'(num_data) + CNT_W'(2) + CNT_W'(has_slot);

endmodule

// File: rtl/tx_bit_sequencer.sv
module tx_bit_sequencer
  import uart_tx_pkg::*;
#(
  parameter int FRAME_W = 11,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  output logic               busy,
  output logic               txd
);

  seq_state_e         state_q, state_n;
  logic [FRAME_W-1:0] shreg_q, shreg_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [CNT_W-1:0]   len_q, len_n;
  logic               txd_q, txd_n;
  logic               reg_en;

  always_comb begin
    state_n = state_q;
    shreg_n = shreg_q;
    cnt_n   = cnt_q;
    len_n   = len_q;
    txd_n   = txd_q;
    unique case (state_q)
      SQ_IDLE: begin
        txd_n = 1'b1;
        if (load) begin
          shreg_n = frame_in;
          len_n   = nbits_in;
          state_n = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (tick) begin
          txd_n   = shreg_q[0];
          shreg_n = {1'b1, shreg_q[FRAME_W-1:1]};
          cnt_n   = len_q;
          state_n = SQ_SEND;
        end
      end
      SQ_SEND: begin
        if (tick) begin
          if (cnt_q == CNT_W'(1)) begin
            txd_n   = 1'b1;
            state_n = SQ_IDLE;
          end else begin
            txd_n   = shreg_q[0];
            shreg_n = {1'b1, shreg_q[FRAME_W-1:1]};
            cnt_n   = cnt_q - CNT_W'(1);
          end
        end
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  assign reg_en = load | tick | (state_q == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      shreg_q <= '1;
      cnt_q   <= '0;
      len_q   <= '0;
      txd_q   <= 1'b1;
    end else if (reg_en) begin
      state_q <= state_n;
      shreg_q <= shreg_n;
      cnt_q   <= cnt_n;
      len_q   <= len_n;
      txd_q   <= txd_n;
    end
  end

  assign busy = (state_q != SQ_IDLE);
  assign txd  = txd_q;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_W     = 8,
  parameter int LEN_CODE_W = 2,
  localparam int FRAME_W   = DATA_W + 3,
  localparam int CNT_W     = $clog2(FRAME_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [DATA_W-1:0]     in_data,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic [1:0]            par_mode,
  input  logic                  par_sel,
  output logic                  txd
);

  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               busy;
  logic               load;

  tx_char_format #(
    .DATA_W     (DATA_W),
    .LEN_CODE_W (LEN_CODE_W)
  ) u_fmt (
    .data     (in_data),
    .len_code (len_code),
    .par_mode (par_mode),
    .par_sel  (par_sel),
    .frame    (frame),
    .nbits    (nbits)
  );

  assign in_ready = ~busy;
  assign load     = in_valid & in_ready;

  tx_bit_sequencer #(
    .FRAME_W (FRAME_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (load),
    .frame_in (frame),
    .nbits_in (nbits),
    .busy     (busy),
    .txd      (txd)
  );

endmodule

// File: rtl/tx_frame_checker.sv
module tx_frame_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic in_valid,
  input logic in_ready,
  input logic txd
);

  // R7: the line moves only on a tick edge
  assert_txd_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (txd != $past(txd)) |-> $past(tick));

  // R7: idle line is high
  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> txd);

  // R8: acceptance drops ready
  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8: ready returns only on a tick
  assert_ready_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(tick));

  // R10: line still high right after acceptance
  assert_wait_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> txd);

endmodule

bind uart_frame_tx tx_frame_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .txd      (txd)
);

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] len_code = '0;
  logic [1:0] par_mode = '0;
  logic       par_sel = 1'b0;
  logic       txd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .len_code(len_code),
    .par_mode(par_mode), .par_sel(par_sel), .txd(txd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input [1:0] lc, input [1:0] pm);
    return 5 + int'(lc) + 2 + ((pm == 2'b10) ? 0 : 1);
  endfunction

  // Bit 0 of the result is the first bit on the line
  function automatic logic [15:0] exp_frame(input [7:0] d, input [1:0] lc,
                                            input [1:0] pm, input s);
    logic [15:0] f = '1;
    int nd = 5 + int'(lc);
    logic p = s;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      f[1+i] = d[i];
      p = p ^ d[i];
    end
    case (pm)
      2'b00: f[1+nd] = p;
      2'b01: f[1+nd] = s;
      2'b11: f[1+nd] = s;
      default: ;
    endcase
    return f;
  endfunction

  function automatic string mode_req(input [1:0] pm);
    case (pm)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic send_tick(input int gap);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_char(input [7:0] d, input [1:0] lc, input [1:0] pm, input s);
    logic [15:0] ef, got;
    int n;
    int gap;
    bit ready_bad = 0;
    bit stable_bad = 0;
    logic held;
    ef = exp_frame(d, lc, pm, s);
    n = exp_len(lc, pm);
    got = '1;
    @(negedge clk);
    in_data = d; len_code = lc; par_mode = pm; par_sel = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R8 ready after accept", in_ready, 0);
    // R9: disturb everything after capture
    in_data = 8'($urandom); len_code = 2'($urandom); par_mode = 2'($urandom);
    par_sel = 1'($urandom);
    repeat (2) @(negedge clk);
    check(txd == 1'b1, "R10 line before first tick", txd, 1);
    for (int k = 0; k < n; k++) begin
      gap = int'($urandom_range(0, 3));
      send_tick(0);
      got[k] = txd;
      held = txd;
      if (in_ready) ready_bad = 1;
      repeat (gap) @(negedge clk);
      if (txd != held) stable_bad = 1;
      if (k == 1) begin
        in_data = ~in_data; par_sel = ~par_sel; par_mode = ~par_mode;
      end
    end
    check(got[0] == 1'b0 && got[n-1] == 1'b1, "R7 start/stop", int'(got), int'(ef));
    check(got == ef, {mode_req(pm), " R2 R9 frame"}, int'(got), int'(ef));
    check(!stable_bad, "R7 line held between ticks", stable_bad, 0);
    check(!ready_bad, "R8 ready low during frame", ready_bad, 0);
    send_tick(0);
    check(in_ready == 1'b1 && txd == 1'b1, "R8 ready after stop",
          {in_ready, txd}, 3);
  endtask

  initial begin
    int unused;
    unused = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && in_ready == 1'b1, "R1 reset state", {txd, in_ready}, 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(txd == 1'b1 && in_ready == 1'b1, "R1 after release", {txd, in_ready}, 3);
    // R7: idle ticks leave the line high
    send_tick(1);
    send_tick(0);
    check(txd == 1'b1, "R7 idle tick", txd, 1);
    // Directed corners: every mode, length extremes, both selector values
    for (int m = 0; m < 4; m++) begin
      send_char(8'hFF, 2'b00, 2'(m), 1'b0);
      send_char(8'hA5, 2'b11, 2'(m), 1'b1);
      send_char(8'h00, 2'b11, 2'(m), 1'b0);
      send_char(8'h3E, 2'b01, 2'(m), 1'b1);
    end
    send_char(8'h80, 2'b10, 2'b00, 1'b0);  // R2: bit 7 unsent at length 7
    send_char(8'hE0, 2'b00, 2'b00, 1'b1);  // R2/R3: upper bits excluded from parity
    for (int r = 0; r < 80; r++) begin
      send_char(8'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule